// File: doc/BRIEF.md
# LIN Frame Receiver with Checksum Check

This block sits behind a UART receiver on a LIN slave node. Once an upstream detector has confirmed the break and sync pattern, it raises `sync_valid` for one cycle. The receiver then treats the next byte as the protected identifier. The low six bits of that byte are the frame ID, and they are looked up in a small table that software loads through a write port. Each table slot holds an ID, a data length and a direction.

For a frame that this node receives, the block gathers the data bytes and then the checksum byte. It checks the checksum with one of two rules, chosen by the ID:

- **Classic rule**: covers the data bytes only.
- **Enhanced rule**: also folds in the protected identifier byte.

A good frame produces a one-cycle success pulse, and the data, ID and length are latched into the result registers. A bad checksum produces an error pulse and leaves the result registers untouched, so the received bytes are thrown away.

Two diagnostic IDs have fixed handling that does not depend on the table. The master-request ID is received as an eight-byte classic frame and is flagged separately. The slave-response ID is announced with a pulse, and the rest of that frame is ignored because this block only receives.

Top module: `lin_frame_rx`

## Requirements
- R1: After reset, all pulse outputs, `res_id`, `res_len` and `res_data` are zero, and the ID table holds no valid slot, so an ID frame sent before any table write produces no pulse.
- R2: While no frame is open (after reset, or after a frame has ended), bytes on `rx_valid` produce no pulse and no change of the result registers.
- R3: The first byte accepted after `sync_valid` is the protected identifier, and its bits [5:0] are the ID. A table slot with that ID and `tbl_dir`=0 makes the block collect `tbl_len_m1`+1 data bytes (the length field encodes 1..8 as 0..7), followed by one checksum byte.
- R4: For an ID of 60 or above, the classic rule applies. The expected checksum byte is the bitwise inverse of the 8-bit sum of the data bytes, where each carry out of bit 7 is added back into bit 0. Example: data FF, 02, 80 gives checksum 7D.
- R5: For an ID below 60, the enhanced rule applies. The sum also includes the whole 8-bit protected identifier byte, so a checksum computed with the classic rule is reported as an error.
- R6: When the checksum matches, `frame_ok` is high for exactly one cycle, starting at the clock edge that accepts the checksum byte. At the same edge, `res_id` takes the ID and `res_len` takes the byte count, and `res_data` holds data byte k at bits [8k+7:8k] with all unused bytes zero.
- R7: When the checksum does not match, `frame_err` is high for one cycle at that edge, `frame_ok` stays low, and `res_data`, `res_id` and `res_len` keep their previous values.
- R8: An ID with no table slot makes the block ignore every byte until the next `sync_valid`.
- R9: An ID whose slot has `tbl_dir`=1 (slave-to-master) makes the block ignore the frame: no data is collected and no pulse is produced.
- R10: ID 60 (master request) is always received as 8 data bytes under the classic rule, without any table slot. A good frame with this ID raises `master_req` together with `frame_ok`.
- R11: ID 61 (slave response) raises `slave_resp` for one cycle at the edge that accepts the identifier byte. The rest of that frame is ignored.
- R12: `sync_valid` in the middle of a frame abandons that frame. The next accepted byte is again taken as a protected identifier. A byte offered in the same cycle as `sync_valid` is dropped.
- R13: Writing a table slot that already holds an entry replaces it. The new length and direction apply from the next frame onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_valid | input | 1 | One-cycle pulse: a valid break/sync has just been seen |
| rx_valid | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte from the UART |
| tbl_we | input | 1 | Table write strobe |
| tbl_slot | input | 3 | Table slot to write |
| tbl_id | input | 6 | Frame ID stored in the slot |
| tbl_len_m1 | input | 3 | Data length minus one |
| tbl_dir | input | 1 | 0 = master-to-slave (receive), 1 = slave-to-master |
| frame_ok | output | 1 | One-cycle pulse: frame accepted with a good checksum |
| frame_err | output | 1 | One-cycle pulse: checksum mismatch, data discarded |
| master_req | output | 1 | One-cycle pulse with `frame_ok` for a master-request frame |
| slave_resp | output | 1 | One-cycle pulse: slave-response ID seen |
| res_id | output | 6 | ID of the last accepted frame |
| res_len | output | 4 | Data byte count of the last accepted frame |
| res_data | output | 64 | Data of the last accepted frame, byte 0 in bits [7:0] |

## Verification
Every result of this block is registered at the clock edge that accepts the byte which decides it, with no further delay:

- `frame_ok`, `frame_err`, `master_req` and the result registers change at the edge that takes the checksum byte.
- `slave_resp` rises at the edge that takes the identifier byte.

The bench applies each byte half a cycle before a rising edge and drops it half a cycle after. It samples the outputs at the falling edge that directly follows the accepting edge, which is the only cycle in which a pulse is visible. For the ignore cases, the bench checks the pulse outputs after every byte. It also confirms that the result registers still show the previous good frame.

// File: rtl/lin_rx_pkg.sv
package lin_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PID  = 2'd1,
    ST_DATA = 2'd2,
    ST_CSUM = 2'd3
  } rx_state_e;

  // 8-bit sum with the carry out folded back into bit 0
  function automatic logic [7:0] carry_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

endpackage

// File: rtl/lin_id_table.sv
module lin_id_table #(
  parameter int N_SLOTS = 8,
  parameter int ID_W    = 6,
  parameter int LEN_W   = 3,
  parameter int SLOT_W  = $clog2(N_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [ID_W-1:0]   wid,
  input  logic [LEN_W-1:0]  wlen,
  input  logic              wdir,
  input  logic [ID_W-1:0]   q_id,
  output logic              hit,
  output logic [LEN_W-1:0]  q_len,
  output logic              q_dir
);

  logic [N_SLOTS-1:0] ent_vld;
  logic [ID_W-1:0]    ent_id  [N_SLOTS];
  logic [LEN_W-1:0]   ent_len [N_SLOTS];
  logic               ent_dir [N_SLOTS];
  logic [N_SLOTS-1:0] match;

  always_ff @(posedge clk) begin
    if (rst) ent_vld <= '0;
    else if (we) ent_vld[wslot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      ent_id[wslot]  <= wid;
      ent_len[wslot] <= wlen;
      ent_dir[wslot] <= wdir;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_SLOTS; g++) begin : g_cmp
      assign match[g] = ent_vld[g] && (ent_id[g] == q_id);
    end
  endgenerate

  // lowest matching slot wins
  always_comb begin
    hit   = |match;
    q_len = '0;
    q_dir = 1'b0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (match[i]) begin
        q_len = ent_len[i];
        q_dir = ent_dir[i];
      end
    end
  end

  // R13
  slot_written_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> ent_vld[$past(wslot)]);

  // R1
  no_hit_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (ent_vld == '0) |-> !hit);

endmodule

// File: rtl/lin_csum_acc.sv
module lin_csum_acc
  import lin_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic [7:0] init,
  input  logic       add,
  input  logic [7:0] din,
  output logic [7:0] sum
);

  always_ff @(posedge clk) begin
    if (rst)      sum <= 8'h00;
    else if (clr) sum <= init;
    else if (add) sum <= carry_add(sum, din);
  end

  // R4
  sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !add) |=> $stable(sum));

endmodule

// File: rtl/lin_data_collect.sv
module lin_data_collect #(
  parameter int MAX_LEN = 8,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = $clog2(MAX_LEN)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      wr,
  input  logic [IDX_W-1:0]          widx,
  input  logic [DATA_W-1:0]         din,
  output logic [MAX_LEN*DATA_W-1:0] dout
);

  genvar g;
  generate
    for (g = 0; g < MAX_LEN; g++) begin : g_lane
      logic [DATA_W-1:0] lane_q;
      always_ff @(posedge clk) begin
        if (rst || clr)                     lane_q <= '0;
        else if (wr && widx == IDX_W'(g))   lane_q <= din;
      end
      assign dout[g*DATA_W +: DATA_W] = lane_q;
    end
  endgenerate

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (dout == '0));

endmodule

// File: rtl/lin_frame_rx.sv
module lin_frame_rx
  import lin_rx_pkg::*;
#(
  parameter int NUM_SLOTS    = 8,
  parameter int MAX_LEN      = 8,
  parameter int ID_W         = 6,
  parameter int CLASSIC_FROM = 60,
  parameter int MREQ_ID      = 60,
  parameter int SRESP_ID     = 61,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int LEN_W  = $clog2(MAX_LEN),
  localparam int CNT_W  = $clog2(MAX_LEN + 1),
  localparam int BUF_W  = MAX_LEN * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_valid,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tbl_we,
  input  logic [SLOT_W-1:0] tbl_slot,
  input  logic [ID_W-1:0]   tbl_id,
  input  logic [LEN_W-1:0]  tbl_len_m1,
  input  logic              tbl_dir,
  output logic              frame_ok,
  output logic              frame_err,
  output logic              master_req,
  output logic              slave_resp,
  output logic [ID_W-1:0]   res_id,
  output logic [CNT_W-1:0]  res_len,
  output logic [BUF_W-1:0]  res_data
);

  rx_state_e         state_q;
  logic [ID_W-1:0]   id_q;
  logic [CNT_W-1:0]  len_q, cnt_q;

  logic [ID_W-1:0]   cur_id;
  logic              t_hit, t_dir;
  logic [LEN_W-1:0]  t_len;
  logic              accept, pid_take, data_take;
  logic              is_mreq, is_sresp, is_classic, do_collect;
  logic [CNT_W-1:0]  new_len;
  logic [7:0]        sum;
  logic [BUF_W-1:0]  coll_buf;

  assign cur_id     = rx_byte[ID_W-1:0];
  assign accept     = rx_valid && !sync_valid;
  assign pid_take   = accept && (state_q == ST_PID);
  assign data_take  = accept && (state_q == ST_DATA);
  assign is_mreq    = (cur_id == ID_W'(MREQ_ID));
  assign is_sresp   = (cur_id == ID_W'(SRESP_ID));
  assign is_classic = (cur_id >= ID_W'(CLASSIC_FROM));
  assign do_collect = !is_sresp && (is_mreq || (t_hit && !t_dir));
  assign new_len    = is_mreq ? CNT_W'(MAX_LEN) : (CNT_W'(t_len) + 1'b1);

  lin_id_table #(
    .N_SLOTS(NUM_SLOTS), .ID_W(ID_W), .LEN_W(LEN_W), .SLOT_W(SLOT_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .we(tbl_we), .wslot(tbl_slot), .wid(tbl_id), .wlen(tbl_len_m1), .wdir(tbl_dir),
    .q_id(cur_id), .hit(t_hit), .q_len(t_len), .q_dir(t_dir)
  );

  lin_csum_acc u_csum (
    .clk(clk), .rst(rst),
    .clr(pid_take), .init(is_classic ? 8'h00 : rx_byte),
    .add(data_take), .din(rx_byte), .sum(sum)
  );

  lin_data_collect #(
    .MAX_LEN(MAX_LEN), .DATA_W(8), .IDX_W(LEN_W)
  ) u_collect (
    .clk(clk), .rst(rst),
    .clr(pid_take), .wr(data_take), .widx(cnt_q[LEN_W-1:0]),
    .din(rx_byte), .dout(coll_buf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      id_q       <= '0;
      len_q      <= '0;
      cnt_q      <= '0;
      frame_ok   <= 1'b0;
      frame_err  <= 1'b0;
      master_req <= 1'b0;
      slave_resp <= 1'b0;
      res_id     <= '0;
      res_len    <= '0;
      res_data   <= '0;
    end else begin
      frame_ok   <= 1'b0;
      frame_err  <= 1'b0;
      master_req <= 1'b0;
      slave_resp <= 1'b0;
      if (sync_valid) begin
        state_q <= ST_PID;
      end else if (rx_valid) begin
        case (state_q)
          ST_PID: begin
            id_q  <= cur_id;
            cnt_q <= '0;
            if (is_sresp) begin
              slave_resp <= 1'b1;
              state_q    <= ST_IDLE;
            end else if (do_collect) begin
              len_q   <= new_len;
              state_q <= ST_DATA;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_DATA: begin
            cnt_q <= cnt_q + 1'b1;
            if ((cnt_q + 1'b1) == len_q) state_q <= ST_CSUM;
          end
          ST_CSUM: begin
            state_q <= ST_IDLE;
            if (~sum == rx_byte) begin
              frame_ok   <= 1'b1;
              master_req <= (id_q == ID_W'(MREQ_ID));
              res_id     <= id_q;
              res_len    <= len_q;
              res_data   <= coll_buf;
            end else begin
              frame_err  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_ok, frame_err, slave_resp}));

  // R6
  ok_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
    frame_ok |-> $past(rx_valid));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_ok |-> ($stable(res_data) && $stable(res_id) && $stable(res_len)));

  // R10
  mreq_with_ok_chk: assert property (@(posedge clk) disable iff (rst)
    master_req |-> (frame_ok && res_id == ID_W'(MREQ_ID)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |=> !(frame_ok || frame_err || slave_resp));

  // R3
  len_range_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA) |-> (len_q != '0 && cnt_q < len_q));

endmodule

// File: tb/lin_frame_rx_tb.sv
module lin_frame_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_valid = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_slot = '0;
  logic [5:0]  tbl_id = '0;
  logic [2:0]  tbl_len_m1 = '0;
  logic        tbl_dir = 1'b0;
  logic        frame_ok, frame_err, master_req, slave_resp;
  logic [5:0]  res_id;
  logic [3:0]  res_len;
  logic [63:0] res_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_frame_rx dut_i (
    .clk(clk), .rst(rst), .sync_valid(sync_valid), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tbl_we(tbl_we), .tbl_slot(tbl_slot), .tbl_id(tbl_id), .tbl_len_m1(tbl_len_m1),
    .tbl_dir(tbl_dir), .frame_ok(frame_ok), .frame_err(frame_err), .master_req(master_req),
    .slave_resp(slave_resp), .res_id(res_id), .res_len(res_len), .res_data(res_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cadd(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

  function automatic logic [7:0] model_cs(input logic [7:0] pid, input logic [63:0] d,
                                          input int n, input bit enh);
    logic [7:0] s;
    s = enh ? pid : 8'h00;
    for (int i = 0; i < n; i++) s = cadd(s, d[8*i +: 8]);
    return ~s;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_byte  = b;
    rx_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_quiet(input logic [7:0] b, input string req);
    send_byte(b);
    chk(req, {61'd0, frame_ok, frame_err, slave_resp}, 64'd0);
  endtask

  task automatic pulse_sync();
    @(negedge clk);
    sync_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sync_valid = 1'b0;
  endtask

  task automatic tbl_write(input logic [2:0] s, input logic [5:0] id,
                           input logic [2:0] lm1, input logic dir);
    @(negedge clk);
    tbl_we = 1'b1; tbl_slot = s; tbl_id = id; tbl_len_m1 = lm1; tbl_dir = dir;
    @(posedge clk);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  // sync, pid, n data bytes, checksum; outputs of the checksum edge are visible on return
  task automatic send_frame(input logic [7:0] pid, input logic [63:0] d, input int n,
                            input logic [7:0] cs);
    pulse_sync();
    send_byte(pid);
    for (int i = 0; i < n; i++) send_byte(d[8*i +: 8]);
    send_byte(cs);
  endtask

  task automatic t_reset();
    chk("R1 pulses", {60'd0, frame_ok, frame_err, master_req, slave_resp}, 64'd0);
    chk("R1 res_id", {58'd0, res_id}, 64'd0);
    chk("R1 res_len", {60'd0, res_len}, 64'd0);
    chk("R1 res_data", res_data, 64'd0);
    pulse_sync();
    send_quiet(8'h50, "R1 empty table");
    send_quiet(8'hA5, "R1 empty table");
    send_quiet(8'h3C, "R1 empty table");
    send_quiet(model_cs(8'h50, 64'h3CA5, 2, 1), "R1 empty table");
  endtask

  task automatic t_presync();
    tbl_write(3'd0, 6'h10, 3'd1, 1'b0);
    send_quiet(8'h50, "R2 no sync");
    send_quiet(8'hA5, "R2 no sync");
    send_quiet(8'h3C, "R2 no sync");
    send_quiet(model_cs(8'h50, 64'h3CA5, 2, 1), "R2 no sync");
    chk("R2 res_data", res_data, 64'd0);
  endtask

  task automatic t_mreq();
    logic [63:0] d = 64'h0807060504030201;
    send_frame(8'h3C, d, 8, model_cs(8'h3C, d, 8, 0));
    chk("R10 ok", {62'd0, frame_ok, master_req}, 64'd3);
    chk("R10 res_id", {58'd0, res_id}, 64'h3C);
    chk("R10 res_len", {60'd0, res_len}, 64'd8);
    chk("R10 res_data", res_data, d);
    @(negedge clk);
    chk("R6 single pulse", {62'd0, frame_ok, master_req}, 64'd0);
  endtask

  task automatic t_enhanced();
    send_frame(8'h50, 64'h3CA5, 2, model_cs(8'h50, 64'h3CA5, 2, 1));
    chk("R5 ok", {61'd0, frame_ok, frame_err, master_req}, 64'd4);
    chk("R6 res_data upper zero", res_data, 64'h3CA5);
    chk("R3 res_len", {60'd0, res_len}, 64'd2);
    chk("R3 res_id", {58'd0, res_id}, 64'h10);
    send_frame(8'h50, 64'h1111, 2, model_cs(8'h50, 64'h1111, 2, 0));
    chk("R5 classic rejected", {62'd0, frame_ok, frame_err}, 64'd1);
  endtask

  task automatic t_classic();
    tbl_write(3'd1, 6'h3E, 3'd2, 1'b0);
    send_frame(8'h3E, 64'h8002FF, 3, 8'h7D);
    chk("R4 ok carry", {62'd0, frame_ok, frame_err}, 64'd2);
    chk("R4 res_data", res_data, 64'h8002FF);
    send_frame(8'h3E, 64'h8002FF, 3, model_cs(8'h3E, 64'h8002FF, 3, 1));
    chk("R4 enhanced rejected", {62'd0, frame_ok, frame_err}, 64'd1);
  endtask

  task automatic t_error();
    send_frame(8'h50, 64'h2211, 2, model_cs(8'h50, 64'h2211, 2, 1) ^ 8'h01);
    chk("R7 err pulse", {62'd0, frame_ok, frame_err}, 64'd1);
    chk("R7 data kept", res_data, 64'h8002FF);
    chk("R7 id kept", {58'd0, res_id}, 64'h3E);
    chk("R7 len kept", {60'd0, res_len}, 64'd3);
  endtask

  task automatic t_unknown();
    pulse_sync();
    send_quiet(8'h05, "R8 unknown id");
    send_quiet(8'h50, "R8 unknown id");
    send_quiet(8'hA5, "R8 unknown id");
    send_quiet(8'h3C, "R8 unknown id");
    send_quiet(model_cs(8'h50, 64'h3CA5, 2, 1), "R8 unknown id");
    chk("R8 data kept", res_data, 64'h8002FF);
  endtask

  task automatic t_direction();
    tbl_write(3'd2, 6'h20, 3'd0, 1'b1);
    pulse_sync();
    send_quiet(8'h20, "R9 publish id");
    send_quiet(8'h77, "R9 publish id");
    send_quiet(model_cs(8'h20, 64'h77, 1, 1), "R9 publish id");
    chk("R9 data kept", res_data, 64'h8002FF);
  endtask

  task automatic t_sresp();
    pulse_sync();
    send_byte(8'h7D);
    chk("R11 slave_resp", {61'd0, frame_ok, frame_err, slave_resp}, 64'd1);
    for (int i = 0; i < 9; i++) send_quiet(8'h00, "R11 ignored");
  endtask

  task automatic t_midsync();
    tbl_write(3'd3, 6'h11, 3'd7, 1'b0);
    pulse_sync();
    send_quiet(8'h11, "R12 partial");
    send_quiet(8'h01, "R12 partial");
    send_quiet(8'h02, "R12 partial");
    send_frame(8'h50, 64'h5566, 2, model_cs(8'h50, 64'h5566, 2, 1));
    chk("R12 restart ok", {62'd0, frame_ok, frame_err}, 64'd2);
    chk("R12 res_data", res_data, 64'h5566);
  endtask

  task automatic t_rewrite();
    tbl_write(3'd0, 6'h10, 3'd3, 1'b0);
    send_frame(8'h50, 64'hDEADBEEF, 4, model_cs(8'h50, 64'hDEADBEEF, 4, 1));
    chk("R13 ok", {62'd0, frame_ok, frame_err}, 64'd2);
    chk("R13 res_len", {60'd0, res_len}, 64'd4);
    chk("R13 res_data", res_data, 64'hDEADBEEF);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_presync();
    t_mreq();
    t_enhanced();
    t_classic();
    t_error();
    t_unknown();
    t_direction();
    t_sresp();
    t_midsync();
    t_rewrite();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule